// File: doc/BRIEF.md
# Indirect Address Generator with Post-Modify

This block produces data-memory addresses for register-indirect accesses. It holds a file of eight 16-bit address registers, a 3-bit selector that picks the active register, and a 3-bit history field that keeps the selector's previous value. A 16-bit step register and a 16-bit limit register complete the set. Each access strobe emits the active register as the address. In the same cycle the register is updated in place by a chosen step: none, plus or minus one, plus or minus the step register, or a reverse-carry add or subtract of the step register. The reverse-carry steps serve FFT-style bit-reversed buffers whose size is set by the step register.

The selector can be changed with an access, through a selector-only status load, or through a full status restore. The three routes differ in how they treat the history field. A separate compare strobe tests the active register against the limit register under one of four unsigned relations and latches the outcome in a test flag. Conditional control logic elsewhere uses that flag. The memory the addresses point into sits outside this block.

Top module: `auxAddrUnit`

## Requirements
- R1: After reset every address register, the step register, the limit register, the selector, the history field, the test flag and addrValid are zero.
- R2: When ptrLoadEn is high and neither status load is high, the selector takes ptrNew on the next cycle and the history field takes the old selector value. An access in that same cycle uses the old selector.
- R3: When stPtrEn is high and stRestoreEn is low, the selector takes stVal and the history field keeps its value. This route wins over ptrLoadEn.
- R4: When stRestoreEn is high, both the history field and the selector take stVal. This route wins over every other selector source.
- R5: One cycle after an accessEn strobe, addrValid is high for exactly one cycle and dataAddr holds the value the active register had before that access. With no strobe, addrValid is low.
- R6: stepSel codes apply after the address is taken: 0 keeps the register, 1 adds 1, 2 subtracts 1, 3 adds the step register, 4 subtracts it. All arithmetic is unsigned and wraps modulo 2^16 with no overflow signal.
- R7: stepSel 5 adds the step register and code 6 subtracts it, with the carry or borrow moving from the most significant bit toward bit 0. With a step of 8, the chain starting at 0 runs 0, 8, 4, 12, 2. Subtracting 8 from 0 gives 15.
- R8: stepSel code 7 leaves the active register unchanged.
- R9: On cmpEn, testFlag takes the unsigned relation between the active register and the limit register one cycle later. cmpSel codes: 0 equal, 1 less than, 2 greater than, 3 not equal. Without cmpEn the flag holds.
- R10: A regWe write to the register that an access is post-modifying in the same cycle takes precedence over the step result. idxWe and limWe load the step and limit registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accessEn | input | 1 | Access strobe: emit address and post-modify |
| stepSel | input | 3 | Post-modify code (see R6 to R8) |
| ptrLoadEn | input | 1 | Load selector from ptrNew, pushing history |
| ptrNew | input | 3 | New selector value |
| stPtrEn | input | 1 | Selector-only status load |
| stRestoreEn | input | 1 | Full status restore of history and selector |
| stVal | input | 3 | Value for either status load |
| cmpEn | input | 1 | Compare strobe |
| cmpSel | input | 2 | Compare relation code |
| regWe | input | 1 | Address register write enable |
| regWaddr | input | 3 | Address register write index |
| regWdata | input | 16 | Address register write data |
| idxWe | input | 1 | Step register write enable |
| idxWdata | input | 16 | Step register write data |
| limWe | input | 1 | Limit register write enable |
| limWdata | input | 16 | Limit register write data |
| dataAddr | output | 16 | Generated address |
| addrValid | output | 1 | dataAddr is fresh this cycle |
| testFlag | output | 1 | Latched compare result |
| ptrOut | output | 3 | Current selector |
| bufOut | output | 3 | Selector history field |

## Verification
Every result lands one cycle after its strobe: the address with addrValid, the selector and history after a load, and the flag after a compare. A post-modified value therefore shows up at the next access. The driver sets inputs just after a falling edge and pushes the expected address into a queue. A monitor pops that queue on the following falling edge whenever addrValid is high, half a period after the capturing rising edge. Selector, history and flag checks are taken on that same falling edge, and an idle cycle confirms that the flag holds.

// File: rtl/auxAddrPkg.sv
package auxAddrPkg;

  typedef enum logic [2:0] {
    STEP_HOLD    = 3'd0,
    STEP_INC     = 3'd1,
    STEP_DEC     = 3'd2,
    STEP_ADD_IDX = 3'd3,
    STEP_SUB_IDX = 3'd4,
    STEP_REV_ADD = 3'd5,
    STEP_REV_SUB = 3'd6,
    STEP_RSVD    = 3'd7
  } stepMode_e;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_NE = 2'd3
  } cmpRel_e;

  typedef enum logic [1:0] {
    PSRC_KEEP,
    PSRC_NEW,
    PSRC_STATUS,
    PSRC_RESTORE
  } ptrSrc_e;

  typedef struct packed {
    logic    access;
    logic    modify;
    logic    useIdx;
    logic    subtract;
    logic    bitRev;
    logic    compare;
    cmpRel_e rel;
  } pathCtl_t;

endpackage

// File: rtl/auxStepUnit.sv
module auxStepUnit #(
  parameter int W = 16
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] idx,
  input  logic         useIdx,
  input  logic         subtract,
  input  logic         bitRev,
  output logic [W-1:0] result
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] amount;
  logic [W-1:0] baseRev;
  logic [W-1:0] amtRev;
  logic [W-1:0] sumNorm;
  logic [W-1:0] sumRev;
  logic [W-1:0] sumRevBack;

  assign amount = useIdx ? idx : ONE;

  for (genvar b = 0; b < W; b++) begin : g_rev
    assign baseRev[b]    = base[W-1-b];
    assign amtRev[b]     = amount[W-1-b];
    assign sumRevBack[b] = sumRev[W-1-b];
  end

  always_comb begin
    sumNorm = subtract ? (base - amount) : (base + amount);
    sumRev  = subtract ? (baseRev - amtRev) : (baseRev + amtRev);
    result  = bitRev ? sumRevBack : sumNorm;
  end

endmodule

// File: rtl/auxAddrCtrl.sv
module auxAddrCtrl
  import auxAddrPkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accessEn,
  input  logic [2:0]       stepSel,
  input  logic             cmpEn,
  input  logic [1:0]       cmpSel,
  input  logic             ptrLoadEn,
  input  logic [PTR_W-1:0] ptrNew,
  input  logic             stPtrEn,
  input  logic             stRestoreEn,
  input  logic [PTR_W-1:0] stVal,
  output pathCtl_t         ctl,
  output logic [PTR_W-1:0] curPtr,
  output logic [PTR_W-1:0] prevPtr
);

  ptrSrc_e ptrSrc;

  always_comb begin
    ctl          = '0;
    ctl.access   = accessEn;
    ctl.compare  = cmpEn;
    ctl.rel      = cmpRel_e'(cmpSel);
    case (stepMode_e'(stepSel))
      STEP_INC:     ctl.modify = accessEn;
      STEP_DEC:     begin ctl.modify = accessEn; ctl.subtract = 1'b1; end
      STEP_ADD_IDX: begin ctl.modify = accessEn; ctl.useIdx = 1'b1; end
      STEP_SUB_IDX: begin ctl.modify = accessEn; ctl.useIdx = 1'b1; ctl.subtract = 1'b1; end
      STEP_REV_ADD: begin ctl.modify = accessEn; ctl.useIdx = 1'b1; ctl.bitRev = 1'b1; end
      STEP_REV_SUB: begin
        ctl.modify   = accessEn;
        ctl.useIdx   = 1'b1;
        ctl.bitRev   = 1'b1;
        ctl.subtract = 1'b1;
      end
      default:      ctl.modify = 1'b0;
    endcase
  end

  always_comb begin
    if (stRestoreEn)    ptrSrc = PSRC_RESTORE;
    else if (stPtrEn)   ptrSrc = PSRC_STATUS;
    else if (ptrLoadEn) ptrSrc = PSRC_NEW;
    else                ptrSrc = PSRC_KEEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr  <= '0;
      prevPtr <= '0;
    end else begin
      case (ptrSrc)
        PSRC_RESTORE: begin curPtr <= stVal;  prevPtr <= stVal;  end
        PSRC_STATUS:  curPtr <= stVal;
        PSRC_NEW:     begin curPtr <= ptrNew; prevPtr <= curPtr; end
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/auxAddrPath.sv
module auxAddrPath
  import auxAddrPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_AR = 8,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [PTR_W-1:0]  sel,
  input  logic              regWe,
  input  logic [PTR_W-1:0]  regWaddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              idxWe,
  input  logic [DATA_W-1:0] idxWdata,
  input  logic              limWe,
  input  logic [DATA_W-1:0] limWdata,
  output logic [DATA_W-1:0] dataAddr,
  output logic              addrValid,
  output logic              testFlag
);

  logic [DATA_W-1:0] arFile [NUM_AR];
  logic [DATA_W-1:0] idxReg;
  logic [DATA_W-1:0] limReg;
  logic [DATA_W-1:0] selVal;
  logic [DATA_W-1:0] nextVal;
  logic              relHit;

  assign selVal = arFile[sel];

  auxStepUnit #(.W(DATA_W)) i_step (
    .base     (selVal),
    .idx      (idxReg),
    .useIdx   (ctl.useIdx),
    .subtract (ctl.subtract),
    .bitRev   (ctl.bitRev),
    .result   (nextVal)
  );

  for (genvar gi = 0; gi < NUM_AR; gi++) begin : g_ar
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      q <= '0;
      else if (regWe && regWaddr == PTR_W'(gi))       q <= regWdata;
      else if (ctl.modify && sel == PTR_W'(gi))       q <= nextVal;
    end
    assign arFile[gi] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      limReg <= '0;
    end else begin
      if (idxWe) idxReg <= idxWdata;
      if (limWe) limReg <= limWdata;
    end
  end

  always_comb begin
    case (ctl.rel)
      REL_EQ:  relHit = (selVal == limReg);
      REL_LT:  relHit = (selVal <  limReg);
      REL_GT:  relHit = (selVal >  limReg);
      default: relHit = (selVal != limReg);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataAddr  <= '0;
      addrValid <= 1'b0;
      testFlag  <= 1'b0;
    end else begin
      addrValid <= ctl.access;
      if (ctl.access)  dataAddr <= selVal;
      if (ctl.compare) testFlag <= relHit;
    end
  end

endmodule

// File: rtl/auxAddrUnit.sv
module auxAddrUnit
  import auxAddrPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_AR = 8,
  localparam int PTR_W = $clog2(NUM_AR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessEn,
  input  logic [2:0]        stepSel,
  input  logic              ptrLoadEn,
  input  logic [PTR_W-1:0]  ptrNew,
  input  logic              stPtrEn,
  input  logic              stRestoreEn,
  input  logic [PTR_W-1:0]  stVal,
  input  logic              cmpEn,
  input  logic [1:0]        cmpSel,
  input  logic              regWe,
  input  logic [PTR_W-1:0]  regWaddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              idxWe,
  input  logic [DATA_W-1:0] idxWdata,
  input  logic              limWe,
  input  logic [DATA_W-1:0] limWdata,
  output logic [DATA_W-1:0] dataAddr,
  output logic              addrValid,
  output logic              testFlag,
  output logic [PTR_W-1:0]  ptrOut,
  output logic [PTR_W-1:0]  bufOut
);

  pathCtl_t ctl;

  auxAddrCtrl #(.PTR_W(PTR_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .accessEn    (accessEn),
    .stepSel     (stepSel),
    .cmpEn       (cmpEn),
    .cmpSel      (cmpSel),
    .ptrLoadEn   (ptrLoadEn),
    .ptrNew      (ptrNew),
    .stPtrEn     (stPtrEn),
    .stRestoreEn (stRestoreEn),
    .stVal       (stVal),
    .ctl         (ctl),
    .curPtr      (ptrOut),
    .prevPtr     (bufOut)
  );

  auxAddrPath #(.DATA_W(DATA_W), .NUM_AR(NUM_AR), .PTR_W(PTR_W)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sel       (ptrOut),
    .regWe     (regWe),
    .regWaddr  (regWaddr),
    .regWdata  (regWdata),
    .idxWe     (idxWe),
    .idxWdata  (idxWdata),
    .limWe     (limWe),
    .limWdata  (limWdata),
    .dataAddr  (dataAddr),
    .addrValid (addrValid),
    .testFlag  (testFlag)
  );

endmodule

// File: rtl/auxAddrChk.sv
module auxAddrChk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             accessEn,
  input logic             ptrLoadEn,
  input logic [PTR_W-1:0] ptrNew,
  input logic             stPtrEn,
  input logic             stRestoreEn,
  input logic [PTR_W-1:0] stVal,
  input logic             cmpEn,
  input logic             addrValid,
  input logic             testFlag,
  input logic [PTR_W-1:0] ptrOut,
  input logic [PTR_W-1:0] bufOut
);

  AST_PTR_LOAD_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (ptrLoadEn && !stPtrEn && !stRestoreEn) |=> (ptrOut == $past(ptrNew) && bufOut == $past(ptrOut))); // R2

  AST_STATUS_KEEPS_HISTORY: assert property (@(posedge clk) disable iff (!rstN)
    (stPtrEn && !stRestoreEn) |=> (ptrOut == $past(stVal) && $stable(bufOut))); // R3

  AST_RESTORE_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    stRestoreEn |=> (bufOut == $past(stVal) && ptrOut == $past(stVal))); // R4

  AST_VALID_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    accessEn |=> addrValid); // R5

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !accessEn |=> !addrValid); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cmpEn |=> $stable(testFlag)); // R9

endmodule

bind auxAddrUnit auxAddrChk #(.PTR_W(PTR_W)) i_auxAddrChk (
  .clk         (clk),
  .rstN        (rstN),
  .accessEn    (accessEn),
  .ptrLoadEn   (ptrLoadEn),
  .ptrNew      (ptrNew),
  .stPtrEn     (stPtrEn),
  .stRestoreEn (stRestoreEn),
  .stVal       (stVal),
  .cmpEn       (cmpEn),
  .addrValid   (addrValid),
  .testFlag    (testFlag),
  .ptrOut      (ptrOut),
  .bufOut      (bufOut)
);

// File: tb/test_auxAddrUnit.sv
`timescale 1ns/1ps
module test_auxAddrUnit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        accessEn, ptrLoadEn, stPtrEn, stRestoreEn, cmpEn;
  logic        regWe, idxWe, limWe;
  logic [2:0]  stepSel, ptrNew, stVal, regWaddr;
  logic [1:0]  cmpSel;
  logic [15:0] regWdata, idxWdata, limWdata;
  logic [15:0] dataAddr;
  logic        addrValid, testFlag;
  logic [2:0]  ptrOut, bufOut;

  always #2 clk = ~clk;

  auxAddrUnit i_auxAddrUnit (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .stepSel(stepSel),
    .ptrLoadEn(ptrLoadEn), .ptrNew(ptrNew), .stPtrEn(stPtrEn),
    .stRestoreEn(stRestoreEn), .stVal(stVal), .cmpEn(cmpEn), .cmpSel(cmpSel),
    .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata),
    .idxWe(idxWe), .idxWdata(idxWdata), .limWe(limWe), .limWdata(limWdata),
    .dataAddr(dataAddr), .addrValid(addrValid), .testFlag(testFlag),
    .ptrOut(ptrOut), .bufOut(bufOut)
  );

  int nChecks = 0;
  int nErrors = 0;
  logic [15:0] expQ[$];
  logic [15:0] arM [8];
  logic [2:0]  ptrM, bufM;
  logic [15:0] idxM;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected addresses as valid addresses appear
  always @(negedge clk) begin
    if (rstN === 1'b1 && addrValid === 1'b1) begin
      if (expQ.size() == 0) check("R5 unexpected addrValid", 32'd1, 32'd0);
      else check("R5 R6 address", {16'd0, dataAddr}, {16'd0, expQ.pop_front()});
    end
  end

  task automatic clearIn();
    accessEn = 0; ptrLoadEn = 0; stPtrEn = 0; stRestoreEn = 0; cmpEn = 0;
    regWe = 0; idxWe = 0; limWe = 0; stepSel = 0; ptrNew = 0; stVal = 0;
    regWaddr = 0; cmpSel = 0; regWdata = 0; idxWdata = 0; limWdata = 0;
  endtask

  task automatic endCycle();
    @(negedge clk);
    clearIn();
  endtask

  task automatic access(input logic [2:0] mode);
    accessEn = 1; stepSel = mode;
    expQ.push_back(arM[ptrM]);
    case (mode)
      3'd1: arM[ptrM] = arM[ptrM] + 16'd1;
      3'd2: arM[ptrM] = arM[ptrM] - 16'd1;
      3'd3: arM[ptrM] = arM[ptrM] + idxM;
      3'd4: arM[ptrM] = arM[ptrM] - idxM;
      default: ;
    endcase
    endCycle();
  endtask

  task automatic accessRev(input logic [2:0] mode, input logic [15:0] expA);
    accessEn = 1; stepSel = mode;
    expQ.push_back(expA);
    endCycle();
  endtask

  task automatic writeAr(input logic [2:0] i, input logic [15:0] v);
    regWe = 1; regWaddr = i; regWdata = v; arM[i] = v;
    endCycle();
  endtask

  task automatic loadPtr(input logic [2:0] p);
    ptrLoadEn = 1; ptrNew = p; bufM = ptrM; ptrM = p;
    endCycle();
  endtask

  task automatic doCmp(input logic [1:0] rel, input logic exp, input string tag);
    cmpEn = 1; cmpSel = rel;
    endCycle();
    check(tag, {31'd0, testFlag}, {31'd0, exp});
  endtask

  initial begin
    #(4 * 150000);
    check("watchdog expired", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) arM[i] = 16'd0;
    ptrM = 0; bufM = 0; idxM = 0;
    clearIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R1 reset ptr", {29'd0, ptrOut}, 32'd0);
    check("R1 reset history", {29'd0, bufOut}, 32'd0);
    check("R1 reset flag", {31'd0, testFlag}, 32'd0);
    check("R1 reset addrValid", {31'd0, addrValid}, 32'd0);
    rstN = 1;
    endCycle();

    // R1: registers read back as zero
    loadPtr(3);
    access(0);
    check("R2 ptr after load", {29'd0, ptrOut}, 32'd3);
    check("R2 history after load", {29'd0, bufOut}, 32'd0);

    for (int i = 0; i < 8; i++) writeAr(3'(i), 16'h1000 + 16'(i) * 16'h0011);
    idxWe = 1; idxWdata = 16'h0010; idxM = 16'h0010; endCycle();

    // R6 and R8: linear steps on register 2
    loadPtr(2);
    access(0); access(1); access(2); access(3); access(4);
    access(7); access(7); access(0);

    // R6: wrap both directions
    writeAr(5, 16'hFFFF);
    loadPtr(5);
    access(1); access(2); access(0);

    // R2: access in the same cycle as a pointer load uses the old selector
    ptrLoadEn = 1; ptrNew = 3'd6; bufM = ptrM;
    accessEn = 1; stepSel = 3'd0; expQ.push_back(arM[ptrM]);
    ptrM = 3'd6;
    endCycle();
    check("R2 ptr after load with access", {29'd0, ptrOut}, 32'd6);
    check("R2 history after load with access", {29'd0, bufOut}, 32'd5);
    access(0);

    // R3: selector-only status load keeps history and beats ptrLoadEn
    stPtrEn = 1; stVal = 3'd1; ptrLoadEn = 1; ptrNew = 3'd4;
    endCycle();
    check("R3 ptr from status", {29'd0, ptrOut}, 32'd1);
    check("R3 history unchanged", {29'd0, bufOut}, 32'd5);
    ptrM = 3'd1;
    access(0);

    // R4: full restore writes both, beats the other sources
    stRestoreEn = 1; stPtrEn = 1; stVal = 3'd7; ptrLoadEn = 1; ptrNew = 3'd2;
    endCycle();
    check("R4 ptr restored", {29'd0, ptrOut}, 32'd7);
    check("R4 history restored", {29'd0, bufOut}, 32'd7);
    ptrM = 3'd7; bufM = 3'd7;
    access(0);

    // R7: reverse-carry stepping with step 8
    writeAr(0, 16'd0);
    idxWe = 1; idxWdata = 16'd8; idxM = 16'd8; endCycle();
    loadPtr(0);
    accessRev(5, 16'd0);  accessRev(5, 16'd8); accessRev(5, 16'd4);
    accessRev(5, 16'd12); accessRev(5, 16'd2);
    accessRev(6, 16'd10); accessRev(6, 16'd2); accessRev(6, 16'd12);
    accessRev(0, 16'd4);
    writeAr(1, 16'd0);
    loadPtr(1);
    accessRev(6, 16'd0); accessRev(6, 16'd15); accessRev(0, 16'd7);

    // R9: compare relations
    writeAr(4, 16'h0500);
    limWe = 1; limWdata = 16'h0500; endCycle();
    loadPtr(4);
    doCmp(2'd0, 1'b1, "R9 equal true");
    doCmp(2'd3, 1'b0, "R9 not-equal false");
    doCmp(2'd1, 1'b0, "R9 less false");
    limWe = 1; limWdata = 16'h0600; endCycle();
    doCmp(2'd1, 1'b1, "R9 less true");
    doCmp(2'd2, 1'b0, "R9 greater false");
    limWe = 1; limWdata = 16'h0400; endCycle();
    doCmp(2'd2, 1'b1, "R9 greater true");
    doCmp(2'd3, 1'b1, "R9 not-equal true");
    endCycle();
    check("R9 flag holds", {31'd0, testFlag}, 32'd1);

    // R10: write beats post-modify of the same register
    accessEn = 1; stepSel = 3'd1; expQ.push_back(arM[4]);
    regWe = 1; regWaddr = 3'd4; regWdata = 16'h7777; arM[4] = 16'h7777;
    endCycle();
    access(0);

    repeat (3) endCycle();
    check("R5 all addresses delivered", expQ.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule